// File: doc/BRIEF.md
# LFSR Spatial Dither Reducer

This block narrows a stream of 12-bit-per-channel RGB pixels to 6 or 8 bits per channel. When dithering is on, a small pseudo-random value is added into the bits that are about to be discarded, so that the rounding error turns into spatial noise and does not show up as visible banding. The noise comes from three 28-bit shift-register generators. They can share one feedback polynomial or use a different one per colour. Each generator has its own seed, and the seeds can be reloaded at every frame start with a frame count mixed in.

Pixels enter one per cycle on a valid/ready stream and leave through a single registered stage with the same handshake. A frame-start pulse marks the beginning of each frame. Configuration is presented as plain static inputs: depth, enable, the three seeds, per-channel noise select, per-frame reseed select and high-pass select. When dithering is off, or when a depth that the block cannot dither is selected, the output is a plain truncation.

Top module: `sdith_reducer`

## Requirements
- R1: Depth code 0 yields a 6-bit result in the low 6 bits of each output channel, with the upper 2 bits zero, and discards the 6 low input bits. Depth code 1 yields an 8-bit result and discards the 4 low input bits.
- R2: Depth codes 2 and 3 are not dithered whatever the enable says. The output is the 8-bit truncation, input bits [11:4].
- R3: With the dither enable low, each output channel is the input shifted right by the discarded width (6 for code 0, otherwise 4).
- R4: With dithering active, each channel outputs min(input + noise, 4095) shifted right by the discarded width, so the result saturates at all-ones and never wraps. The noise is the low discarded-width bits of that channel's generator state at acceptance, before the generator steps.
- R5: Each generator is 28 bits wide. One step shifts the state left by one and puts state[27] XOR state[k-1] into bit 0 (polynomial x^28+x^k+1). It steps exactly once per accepted pixel in every mode and holds otherwise.
- R6: With the per-channel select low, all three channels take their noise from the red generator (k=3). With it high, red uses k=3, green k=9 and blue k=13.
- R7: In the first cycle after reset, in_ready is low and each generator loads its own seed. An all-zero load value is replaced by 1.
- R8: With per-frame reseed high, a frame_start loads every generator with seed XOR {24'b0, c[1:0], c[3:2]}, where c is a 4-bit frame counter. The counter then increments and wraps from 15 to 0. A reload in the same cycle as an accepted pixel wins over the step, and that pixel uses the pre-reload noise.
- R9: With per-frame reseed low, frame_start has no effect on the noise and the frame counter is held at 0.
- R10: In high-pass mode the noise is cur - prev when cur >= prev and 0 otherwise. Both values are the low discarded-width bits of the channel's raw sample. prev comes from the previous accepted pixel and is 0 after reset.
- R11: in_ready = seeded AND (NOT out_valid OR out_ready). While out_valid is high and out_ready is low, the output data stays stable. out_valid is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_depth | input | 2 | Output depth code |
| cfg_dith_en | input | 1 | Dither enable |
| cfg_rgb_rand | input | 1 | Per-channel noise polynomials |
| cfg_frame_rand | input | 1 | Reseed generators at every frame start |
| cfg_hipass | input | 1 | High-pass noise shaping |
| cfg_seed_r | input | 28 | Red generator seed |
| cfg_seed_g | input | 28 | Green generator seed |
| cfg_seed_b | input | 28 | Blue generator seed |
| frame_start | input | 1 | Frame start pulse |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_r | input | 12 | Red input |
| in_g | input | 12 | Green input |
| in_b | input | 12 | Blue input |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_r | output | 8 | Red output |
| out_g | output | 8 | Green output |
| out_b | output | 8 | Blue output |

## Verification
The assertions check several rules on every cycle. They cover the ready rule and output stability under backpressure, and the zero upper bits at 6-bit depth. They cover plain truncation when dithering is off or the depth code is unsupported, saturation of a full-scale input, and generators that hold whenever nothing is accepted or loaded. The actual noise values can only be shown by the bench's scenarios, which run a reference generator model: shared versus per-channel taps, high-pass differencing, once-only seeding, frame-start reloads with the counter mix and its wrap, reload priority over a step, and the single step after a stall.

// File: rtl/sdith_pkg.sv
package sdith_pkg;
    localparam int CH = 3;

    typedef enum logic [1:0] {
        DEP_NARROW = 2'd0,
        DEP_WIDE   = 2'd1,
        DEP_RSV2   = 2'd2,
        DEP_RSV3   = 2'd3
    } depth_e;
endpackage

// File: rtl/sdith_lfsr.sv
module sdith_lfsr #(
    parameter int W   = 28,
    parameter int TAP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         adv_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            // an all-zero state would lock the generator
            st_d = (load_val_i == '0) ? W'(1) : load_val_i;
        end else if (adv_i) begin
            st_d = {st_q[W-2:0], st_q[W-1] ^ st_q[TAP-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= W'(1);
        else        st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/sdith_chan.sv
module sdith_chan #(
    parameter int IN_W     = 12,
    parameter int OUT_W    = 8,
    parameter int NARROW_W = 6
) (
    input  logic [IN_W-1:0]          pix_i,
    input  logic [IN_W-NARROW_W-1:0] raw_i,
    input  logic [IN_W-NARROW_W-1:0] prev_i,
    input  logic                     narrow_i,
    input  logic                     dith_i,
    input  logic                     hipass_i,
    output logic [OUT_W-1:0]         pix_o
);
    localparam int DROP_N = IN_W - NARROW_W;
    localparam int DROP_W = IN_W - OUT_W;

    logic [DROP_N-1:0] mask, cur, pv, nz;
    logic [IN_W:0]     sum;
    logic [IN_W-1:0]   sat;

    always_comb begin
        mask = narrow_i ? {DROP_N{1'b1}} : ({DROP_N{1'b1}} >> (DROP_N - DROP_W));
        cur  = raw_i & mask;
        pv   = prev_i & mask;
        if (hipass_i) nz = (cur >= pv) ? (cur - pv) : '0;
        else          nz = cur;
        if (!dith_i)  nz = '0;
        sum = {1'b0, pix_i} + (IN_W+1)'(nz);
        sat = sum[IN_W] ? {IN_W{1'b1}} : sum[IN_W-1:0];
        pix_o = narrow_i ? OUT_W'(sat >> DROP_N) : OUT_W'(sat >> DROP_W);
    end
endmodule

// File: rtl/sdith_reducer.sv
module sdith_reducer #(
    parameter int IN_W      = 12,
    parameter int OUT_W     = 8,
    parameter int NARROW_W  = 6,
    parameter int LFSR_W    = 28,
    parameter int TAP_R     = 3,
    parameter int TAP_G     = 9,
    parameter int TAP_B     = 13,
    parameter int FRAME_MAX = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_dith_en,
    input  logic              cfg_rgb_rand,
    input  logic              cfg_frame_rand,
    input  logic              cfg_hipass,
    input  logic [LFSR_W-1:0] cfg_seed_r,
    input  logic [LFSR_W-1:0] cfg_seed_g,
    input  logic [LFSR_W-1:0] cfg_seed_b,
    input  logic              frame_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IN_W-1:0]   in_r,
    input  logic [IN_W-1:0]   in_g,
    input  logic [IN_W-1:0]   in_b,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OUT_W-1:0]  out_r,
    output logic [OUT_W-1:0]  out_g,
    output logic [OUT_W-1:0]  out_b
);
    import sdith_pkg::*;

    localparam int NZ_W  = IN_W - NARROW_W;
    localparam int CNT_W = $clog2(FRAME_MAX + 1);
    localparam int HALF  = CNT_W / 2;

    typedef struct packed {
        logic                     seeded;
        logic [CNT_W-1:0]         fcnt;
        logic [CH-1:0][NZ_W-1:0]  prev;
        logic                     ovalid;
        logic [CH-1:0][OUT_W-1:0] opix;
    } st_t;

    st_t s_d, s_q;

    logic [CH-1:0][IN_W-1:0]   pix_in;
    logic [CH-1:0][LFSR_W-1:0] seeds;
    logic [CH-1:0][LFSR_W-1:0] lfsr_st;
    logic [CH-1:0][NZ_W-1:0]   raw;
    logic [CH-1:0][OUT_W-1:0]  chan_out;
    logic [CNT_W-1:0]          cnt_swap;
    logic [LFSR_W-1:0]         mix;
    logic                      ld_any, accept, narrow, dith;
    depth_e                    dep;

    assign pix_in = {in_b, in_g, in_r};
    assign seeds  = {cfg_seed_b, cfg_seed_g, cfg_seed_r};
    assign dep    = depth_e'(cfg_depth);
    assign narrow = (dep == DEP_NARROW);
    assign dith   = cfg_dith_en && (dep == DEP_NARROW || dep == DEP_WIDE);

    assign in_ready = s_q.seeded && (!s_q.ovalid || out_ready);
    assign accept   = in_valid && in_ready;
    assign ld_any   = !s_q.seeded || (cfg_frame_rand && frame_start);

    // counter halves exchanged before mixing into the seed
    assign cnt_swap = {s_q.fcnt[HALF-1:0], s_q.fcnt[CNT_W-1:HALF]};
    assign mix      = (s_q.seeded && cfg_frame_rand) ? LFSR_W'(cnt_swap) : '0;

    for (genvar i = 0; i < CH; i++) begin : g_ch
        localparam int TAP = (i == 0) ? TAP_R : ((i == 1) ? TAP_G : TAP_B);

        sdith_lfsr #(
            .W   (LFSR_W),
            .TAP (TAP)
        ) u_lfsr (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (ld_any),
            .load_val_i (seeds[i] ^ mix),
            .adv_i      (accept),
            .state_o    (lfsr_st[i])
        );

        assign raw[i] = cfg_rgb_rand ? lfsr_st[i][NZ_W-1:0] : lfsr_st[0][NZ_W-1:0];

        sdith_chan #(
            .IN_W     (IN_W),
            .OUT_W    (OUT_W),
            .NARROW_W (NARROW_W)
        ) u_chan (
            .pix_i    (pix_in[i]),
            .raw_i    (raw[i]),
            .prev_i   (s_q.prev[i]),
            .narrow_i (narrow),
            .dith_i   (dith),
            .hipass_i (cfg_hipass),
            .pix_o    (chan_out[i])
        );
    end

    always_comb begin
        s_d        = s_q;
        s_d.seeded = 1'b1;

        if (!cfg_frame_rand) begin
            s_d.fcnt = '0;
        end else if (s_q.seeded && frame_start) begin
            s_d.fcnt = (s_q.fcnt == CNT_W'(FRAME_MAX)) ? '0 : s_q.fcnt + 1'b1;
        end

        if (accept) begin
            s_d.prev   = raw;
            s_d.ovalid = 1'b1;
            s_d.opix   = chan_out;
        end else if (out_ready) begin
            s_d.ovalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.ovalid;
    assign out_r     = s_q.opix[0];
    assign out_g     = s_q.opix[1];
    assign out_b     = s_q.opix[2];
endmodule

module sdith_reducer_chk #(
    parameter int IN_W     = 12,
    parameter int OUT_W    = 8,
    parameter int NARROW_W = 6,
    parameter int LFSR_W   = 28,
    parameter int CH       = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_ready,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [1:0]               cfg_depth,
    input logic                     cfg_dith_en,
    input logic [IN_W-1:0]          in_r,
    input logic [IN_W-1:0]          in_g,
    input logic [OUT_W-1:0]         out_r,
    input logic [OUT_W-1:0]         out_g,
    input logic [OUT_W-1:0]         out_b,
    input logic [CH-1:0][LFSR_W-1:0] lfsr_st,
    input logic                     ld_any
);
    logic acc;
    assign acc = in_valid && in_ready;

    p_ready_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid || out_ready));

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_r) && $stable(out_g) && $stable(out_b)));

    p_narrow_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cfg_depth == 2'd0) |=> (out_r[OUT_W-1:NARROW_W] == '0 &&
                                        out_g[OUT_W-1:NARROW_W] == '0 &&
                                        out_b[OUT_W-1:NARROW_W] == '0));

    p_trunc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cfg_dith_en && cfg_depth == 2'd1) |=> (out_r == $past(in_r[IN_W-1 -: OUT_W])));

    p_unsup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cfg_depth[1]) |=> (out_g == $past(in_g[IN_W-1 -: OUT_W])));

    p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cfg_depth == 2'd1 && in_r == {IN_W{1'b1}}) |=> (out_r == {OUT_W{1'b1}}));

    p_gen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !ld_any) |=> $stable(lfsr_st));
endmodule

bind sdith_reducer sdith_reducer_chk #(
    .IN_W     (IN_W),
    .OUT_W    (OUT_W),
    .NARROW_W (NARROW_W),
    .LFSR_W   (LFSR_W),
    .CH       (sdith_pkg::CH)
) u_chk (.*);

// File: tb/sdith_reducer_tb_top.sv
`timescale 1ns/1ps
module sdith_reducer_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [1:0]  cfg_depth = 2'd1;
    logic        cfg_dith_en = 1'b1, cfg_rgb_rand = 1'b0, cfg_frame_rand = 1'b0, cfg_hipass = 1'b0;
    logic [27:0] cfg_seed_r = 28'h5A3C0F1, cfg_seed_g = 28'h1234567, cfg_seed_b = 28'hBEEF001;
    logic        frame_start = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
    logic        in_ready, out_valid;
    logic [11:0] in_r = '0, in_g = '0, in_b = '0;
    logic [7:0]  out_r, out_g, out_b;

    sdith_reducer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_dith_en(cfg_dith_en),
        .cfg_rgb_rand(cfg_rgb_rand), .cfg_frame_rand(cfg_frame_rand), .cfg_hipass(cfg_hipass),
        .cfg_seed_r(cfg_seed_r), .cfg_seed_g(cfg_seed_g), .cfg_seed_b(cfg_seed_b),
        .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    int n_chk = 0;
    int n_err = 0;
    string cur_tag = "R4";

    logic [27:0] m_s [3];
    logic [5:0]  m_prev [3];
    logic [3:0]  m_cnt;

    typedef struct packed {
        logic [1:0]  dep;
        logic        en, rgb, hp;
        logic [11:0] r, g, b;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'd1, 1'b1, 1'b0, 1'b0, 12'h123, 12'h456, 12'h789},
        '{2'd1, 1'b1, 1'b0, 1'b0, 12'h0F8, 12'hAAA, 12'h555},
        '{2'd0, 1'b1, 1'b0, 1'b0, 12'h7C1, 12'h03F, 12'hFC0},
        '{2'd0, 1'b1, 1'b1, 1'b0, 12'h800, 12'h13A, 12'h9E7},
        '{2'd1, 1'b1, 1'b1, 1'b0, 12'h2B7, 12'h6D1, 12'hF03},
        '{2'd1, 1'b0, 1'b1, 1'b0, 12'hABC, 12'hDEF, 12'h123},
        '{2'd0, 1'b0, 1'b0, 1'b0, 12'h8FF, 12'h041, 12'h7BF},
        '{2'd2, 1'b1, 1'b1, 1'b0, 12'h5A5, 12'hC3C, 12'h0FF},
        '{2'd3, 1'b1, 1'b0, 1'b1, 12'h333, 12'h777, 12'hEEE},
        '{2'd0, 1'b1, 1'b1, 1'b1, 12'h10F, 12'hA2E, 12'h5D3},
        '{2'd1, 1'b1, 1'b1, 1'b1, 12'h4C7, 12'hB38, 12'h69A},
        '{2'd1, 1'b1, 1'b0, 1'b1, 12'hFF8, 12'h00C, 12'h7E1}
    };

    function automatic logic [27:0] seed_of(int i);
        return (i == 0) ? cfg_seed_r : ((i == 1) ? cfg_seed_g : cfg_seed_b);
    endfunction

    function automatic int tap_of(int i);
        return (i == 0) ? 3 : ((i == 1) ? 9 : 13);
    endfunction

    function automatic logic [5:0] raw_of(int i);
        return cfg_rgb_rand ? m_s[i][5:0] : m_s[0][5:0];
    endfunction

    function automatic logic [7:0] exp_ch(int i, logic [11:0] pix);
        logic [5:0]  mask, cur, pv, n;
        logic [12:0] sum;
        mask = (cfg_depth == 2'd0) ? 6'h3F : 6'h0F;
        cur  = raw_of(i) & mask;
        pv   = m_prev[i] & mask;
        n    = cfg_hipass ? ((cur >= pv) ? cur - pv : 6'd0) : cur;
        if (!(cfg_dith_en && cfg_depth < 2'd2)) n = 6'd0;
        sum = {1'b0, pix} + {7'd0, n};
        if (sum[12]) sum = 13'h0FFF;
        return (cfg_depth == 2'd0) ? {2'b00, sum[11:6]} : sum[11:4];
    endfunction

    task automatic do_load();
        for (int i = 0; i < 3; i++) begin
            logic [27:0] v;
            v = seed_of(i) ^ {24'd0, m_cnt[1:0], m_cnt[3:2]};
            if (v == 28'd0) v = 28'd1;
            m_s[i] = v;
        end
        m_cnt = (m_cnt == 4'd15) ? 4'd0 : m_cnt + 4'd1;
    endtask

    task automatic model_accept(logic fs);
        logic [5:0] rw [3];
        for (int i = 0; i < 3; i++) rw[i] = raw_of(i);
        for (int i = 0; i < 3; i++) m_prev[i] = rw[i];
        if (fs && cfg_frame_rand) do_load();
        else for (int i = 0; i < 3; i++) m_s[i] = {m_s[i][26:0], m_s[i][27] ^ m_s[i][tap_of(i)-1]};
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(logic [11:0] r, logic [11:0] g, logic [11:0] b, logic fs);
        logic [7:0] er, eg, eb;
        @(negedge clk);
        in_r = r; in_g = g; in_b = b; in_valid = 1'b1; frame_start = fs;
        while (!in_ready) @(negedge clk);
        er = exp_ch(0, r); eg = exp_ch(1, g); eb = exp_ch(2, b);
        model_accept(fs);
        @(negedge clk);
        in_valid = 1'b0; frame_start = 1'b0;
        check({cur_tag, " R11 valid"}, {7'd0, out_valid}, 8'd1);
        check({cur_tag, " red"}, out_r, er);
        check({cur_tag, " green"}, out_g, eg);
        check({cur_tag, " blue"}, out_b, eb);
    endtask

    task automatic fs_pulse();
        @(negedge clk);
        frame_start = 1'b1;
        @(posedge clk);
        if (cfg_frame_rand) do_load();
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] ea_r, eb_r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7: not ready until the seeds are loaded; R11: output empty after reset
        check("R7 ready before seeding", {7'd0, in_ready}, 8'd0);
        check("R11 valid after reset", {7'd0, out_valid}, 8'd0);
        for (int i = 0; i < 3; i++) begin m_s[i] = seed_of(i); m_prev[i] = 6'd0; end
        m_cnt = 4'd0;
        @(negedge clk);
        check("R7 ready after seeding", {7'd0, in_ready}, 8'd1);

        // table walk: R1, R2, R3, R4, R5, R6, R10
        for (int v = 0; v < 12; v++) begin
            cfg_depth = VECS[v].dep; cfg_dith_en = VECS[v].en;
            cfg_rgb_rand = VECS[v].rgb; cfg_hipass = VECS[v].hp;
            cur_tag = VECS[v].dep[1] ? "R2" : (!VECS[v].en ? "R3" :
                      (VECS[v].hp ? "R10" : (VECS[v].rgb ? "R6" : (VECS[v].dep == 2'd0 ? "R1" : "R4"))));
            push(VECS[v].r, VECS[v].g, VECS[v].b, 1'b0);
        end

        // R4 saturation at both depths
        cfg_dith_en = 1'b1; cfg_rgb_rand = 1'b1; cfg_hipass = 1'b0; cfg_depth = 2'd1;
        cur_tag = "R4 sat8";
        push(12'hFFF, 12'hFFF, 12'hFFF, 1'b0);
        check("R4 sat8 literal", out_r, 8'hFF);
        cfg_depth = 2'd0; cur_tag = "R4 sat6";
        push(12'hFFF, 12'hFFF, 12'hFFF, 1'b0);
        check("R1 sat6 literal", out_b, 8'h3F);

        // R9: frame start ignored without per-frame reseed
        cfg_frame_rand = 1'b0; cur_tag = "R9";
        fs_pulse();
        push(12'h3A1, 12'h7F7, 12'h0C9, 1'b0);
        push(12'h3A1, 12'h7F7, 12'h0C9, 1'b1);

        // R8: reload each frame, counter wraps after 15
        cfg_frame_rand = 1'b1; cur_tag = "R8";
        for (int f = 0; f < 18; f++) begin
            fs_pulse();
            push(12'h2C5 + 12'(f * 37), 12'h915, 12'h46E, 1'b0);
        end
        // R8: reload and acceptance in one cycle
        cur_tag = "R8 same-cycle";
        push(12'h555, 12'h666, 12'h777, 1'b1);
        push(12'h555, 12'h666, 12'h777, 1'b0);

        // R11 / R5: backpressure stalls output and generators
        cfg_frame_rand = 1'b0; cfg_depth = 2'd1; cur_tag = "R11 stall";
        @(negedge clk);
        m_cnt = 4'd0;
        out_ready = 1'b0;
        ea_r = exp_ch(0, 12'h1E7);
        push(12'h1E7, 12'h2E7, 12'h3E7, 1'b0);
        in_r = 12'h9A3; in_g = 12'h8B4; in_b = 12'h7C5; in_valid = 1'b1;
        check("R11 ready low when stalled", {7'd0, in_ready}, 8'd0);
        @(negedge clk);
        @(negedge clk);
        check("R11 data held", out_r, ea_r);
        check("R11 still blocked", {7'd0, in_ready}, 8'd0);
        out_ready = 1'b1;
        eb_r = exp_ch(0, 12'h9A3);
        model_accept(1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 single step after stall", out_r, eb_r);
        cur_tag = "R5 follow";
        push(12'h0AB, 12'h0CD, 12'h0EF, 1'b0);

        finish_run();
    end
endmodule